// File: doc/BRIEF.md
# Two-Phase Duty-Cycle Pulse Generator

This block drives a single output from an 8-bit down-counter. The output alternates between a high phase and a low phase, and each phase has its own length register. The high phase lasts n count pulses and the low phase lasts m count pulses, so the duty cycle is n/(n+m). A mode bit selects between this two-phase pulse mode and a plain toggle mode. In toggle mode the counter reloads n on every underflow and the output inverts, which gives a divide-by-two square wave of the underflow rate.

Software writes the two lengths and the mode bit through a small write port. A count pulse input (`tick`) advances the counter. It comes from a prescaler outside this block. A one-cycle interrupt pulse marks every rising edge of the output. A zero length pins the output at a fixed level. The rules for this are listed below, and a zero n takes priority over a zero m.

Top module: `duty_pwm_gen`

## Requirements
- R1: After synchronous reset the output and the interrupt are low, both lengths are 0 and toggle mode is selected.
- R2: A write with `wr_en` high stores `wr_data` into the high length n when `wr_sel`=0 and into the low length m when `wr_sel`=1. When `wr_sel`=2 it stores `wr_data[0]` as the mode bit (1 = pulse mode, 0 = toggle mode). When `wr_sel`=3 the write changes nothing.
- R3: In pulse mode with n and m both non-zero, the output is high for exactly n count pulses and then low for exactly m count pulses, repeating.
- R4: In pulse mode with n = 0, the output goes low at the next phase end and stays low, and no interrupt is produced.
- R5: In pulse mode with m = 0 and n non-zero, the output goes high at the next phase end and stays high.
- R6: When n and m are both 0 in pulse mode, the output is low.
- R7: `irq` is high for exactly one cycle, in the cycle in which the output has just risen, in both modes. It is high at no other time.
- R8: In toggle mode the counter counts down to 0. The count pulse that finds it at 0 reloads n and inverts the output, so the output inverts once every n+1 count pulses.
- R9: A write that turns pulse mode on while it was off drives the output low and clears the counter on that clock edge, and a count pulse in the same cycle is ignored. The next count pulse then starts the high phase.
- R10: Without a count pulse or a mode entry, the output does not change.
- R11: A new n or m written in the middle of a phase does not change the length of the phase in progress. It applies from the next phase that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count pulse enable, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 high length, 1 low length, 2 mode, 3 none |
| wr_data | input | W (8) | Write data |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | One-cycle pulse on each rising edge of the output |

## Verification
Two events can fall in the same cycle: a register write and a phase boundary. When that happens, the counter must load the old length and the register must take the new one. Mode entry and a count pulse can also arrive together, and then the entry must win. The random phase puts writes, mode toggles and count pulses in the same cycles, with lengths kept small so that phase boundaries come often. A cycle model in the bench, built from the requirements, predicts `pwm_out` and `irq` after every edge. Directed cases check mid-phase writes, entry with a simultaneous pulse, and measured high, low and toggle counts.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;

    localparam int unsigned PWM_W_DEF = 8;

    typedef enum logic [1:0] {
        SEL_HIGH = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Decision taken at the end of a pulse-mode phase.
    typedef struct packed {
        logic level;  // output level of the coming phase
        logic hold;   // level is pinned by a zero length
        logic rise;   // output goes 0 -> 1 at this boundary
    } step_t;

    function automatic step_t pick_next(input logic n_zero,
                                        input logic m_zero,
                                        input logic cur_level);
        step_t s;
        if (n_zero) begin
            s.level = 1'b0;
            s.hold  = 1'b1;
        end else if (m_zero) begin
            s.level = 1'b1;
            s.hold  = 1'b1;
        end else begin
            s.level = ~cur_level;
            s.hold  = 1'b0;
        end
        s.rise = s.level & ~cur_level;
        return s;
    endfunction

endpackage

// File: rtl/duty_pwm_cfg.sv
module duty_pwm_cfg
    import duty_pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] hi_val,
    output logic [W-1:0] lo_val,
    output logic         pwm_mode,
    output logic         mode_enter
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    assign mode_enter = wr_en && (sel == SEL_MODE) && wr_data[0] && !pwm_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_val   <= '0;
            lo_val   <= '0;
            pwm_mode <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_HIGH: hi_val   <= wr_data;
                SEL_LOW:  lo_val   <= wr_data;
                SEL_MODE: pwm_mode <= wr_data[0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/duty_pwm_engine.sv
module duty_pwm_engine
    import duty_pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] hi_val,
    input  logic [W-1:0] lo_val,
    input  logic         pwm_mode,
    input  logic         mode_enter,
    output logic         level,
    output logic         irq
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic         phase_end;
    step_t        nxt;

    assign phase_end = (cnt <= ONE);
    assign nxt       = pick_next(hi_val == '0, lo_val == '0, level);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            level <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (mode_enter) begin
                cnt   <= '0;
                level <= 1'b0;
            end else if (tick) begin
                if (pwm_mode) begin
                    if (!phase_end) begin
                        cnt <= cnt - ONE;
                    end else begin
                        level <= nxt.level;
                        irq   <= nxt.rise;
                        if (nxt.hold)
                            cnt <= '0;
                        else
                            cnt <= nxt.level ? hi_val : lo_val;
                    end
                end else begin
                    if (cnt == '0) begin
                        cnt   <= hi_val;
                        level <= ~level;
                        irq   <= ~level;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/duty_pwm_gen.sv
module duty_pwm_gen
    import duty_pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out,
    output logic         irq
);

    logic [W-1:0] hi_val;
    logic [W-1:0] lo_val;
    logic         pwm_mode;
    logic         mode_enter;

    duty_pwm_cfg #(.W(W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .hi_val     (hi_val),
        .lo_val     (lo_val),
        .pwm_mode   (pwm_mode),
        .mode_enter (mode_enter)
    );

    duty_pwm_engine #(.W(W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .hi_val     (hi_val),
        .lo_val     (lo_val),
        .pwm_mode   (pwm_mode),
        .mode_enter (mode_enter),
        .level      (pwm_out),
        .irq        (irq)
    );

endmodule

// File: rtl/duty_pwm_checker.sv
module duty_pwm_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         pwm_out,
    input logic         irq,
    input logic [W-1:0] hi_val,
    input logic         pwm_mode,
    input logic         mode_enter
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_irq_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && irq) |-> (pwm_out && !$past(pwm_out)));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tick) && !$past(mode_enter)) |-> $stable(pwm_out));

    assert_entry_low_R9: assert property (@(posedge clk) disable iff (rst)
        mode_enter |=> (!pwm_out && !irq));

    assert_no_rise_n0_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && irq && $past(pwm_mode)) |-> ($past(hi_val) != '0));

endmodule

bind duty_pwm_gen duty_pwm_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .pwm_out    (pwm_out),
    .irq        (irq),
    .hi_val     (hi_val),
    .pwm_mode   (pwm_mode),
    .mode_enter (mode_enter)
);

// File: tb/duty_pwm_gen_tb.sv
module duty_pwm_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_hi = 0, m_lo = 0, m_cnt = 0;
    bit m_pwm = 0, m_out = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duty_pwm_gen #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // model step written from the requirements
    task automatic model_step(input bit tk, input bit we, input int sel, input int d);
        bit enter, nl, hold;
        enter = we && sel == 2 && d[0] && !m_pwm;
        m_irq = 0;
        if (enter) begin
            m_cnt = 0; m_out = 0;                       // R9
        end else if (tk) begin
            if (m_pwm) begin
                if (m_cnt > 1) m_cnt--;
                else begin
                    if (m_hi == 0)      begin nl = 0; hold = 1; end  // R4 R6
                    else if (m_lo == 0) begin nl = 1; hold = 1; end  // R5
                    else                begin nl = !m_out; hold = 0; end // R3
                    m_irq = nl && !m_out;
                    m_cnt = hold ? 0 : (nl ? m_hi : m_lo);
                    m_out = nl;
                end
            end else begin
                if (m_cnt == 0) begin                    // R8
                    m_cnt = m_hi; m_irq = !m_out; m_out = !m_out;
                end else m_cnt--;
            end
        end
        if (we) begin                                    // R2 R11
            case (sel)
                0: m_hi = d;
                1: m_lo = d;
                2: m_pwm = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input bit tk, input bit we, input int sel, input int d);
        @(negedge clk);
        tick = tk; wr_en = we; wr_sel = 2'(sel); wr_data = W'(d);
        model_step(tk, we, sel, d);
        @(posedge clk);
        #1;
        tick = 0; wr_en = 0;
        check(tag, "pwm_out", int'(pwm_out), int'(m_out));
        check(tag, "irq", int'(irq), int'(m_irq));
    endtask

    task automatic wr(input int sel, input int d);
        cyc(0, 1, sel, d);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    endtask

    initial begin
        int hi_cnt, lo_cnt, rises, toggles;
        bit prev;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        tag = "R1";
        check("R1", "reset pwm_out", int'(pwm_out), 0);
        check("R1", "reset irq", int'(irq), 0);

        // R8: toggle mode, n=3 -> inversion every 4 pulses
        tag = "R8";
        wr(0, 3);
        toggles = 0; rises = 0; prev = pwm_out;
        for (int i = 0; i < 40; i++) begin
            cyc(1, 0, 0, 0);
            if (pwm_out != prev) toggles++;
            if (irq) rises++;
            prev = pwm_out;
        end
        check("R8", "toggle count", toggles, 10);
        check("R7", "rise count toggle", rises, 5);

        // R3/R9: pulse mode n=2 m=3
        tag = "R3";
        wr(0, 2); wr(1, 3);
        tag = "R9";
        cyc(1, 1, 2, 1);                 // entry with simultaneous pulse
        check("R9", "entry forces low", int'(pwm_out), 0);
        tag = "R3";
        hi_cnt = 0; lo_cnt = 0; rises = 0;
        for (int i = 0; i < 25; i++) begin
            cyc(1, 0, 0, 0);
            if (pwm_out) hi_cnt++; else lo_cnt++;
            if (irq) rises++;
        end
        check("R3", "high samples", hi_cnt, 10);
        check("R3", "low samples", lo_cnt, 15);
        check("R7", "rise count pwm", rises, 5);

        // R10: no pulse, no change
        tag = "R10";
        prev = pwm_out;
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);
        check("R10", "hold without tick", int'(pwm_out), int'(prev));

        // R11: mid-phase write
        tag = "R11";
        run_ticks(1);
        wr(0, 6); wr(1, 1);
        run_ticks(20);

        // R2: select 3 ignored
        tag = "R2";
        wr(3, 0);
        run_ticks(10);

        // R4 / R5 / R6
        tag = "R4"; wr(0, 0); run_ticks(12);
        check("R4", "n=0 low", int'(pwm_out), 0);
        tag = "R5"; wr(0, 4); wr(1, 0); run_ticks(12);
        check("R5", "m=0 high", int'(pwm_out), 1);
        tag = "R6"; wr(0, 0); run_ticks(8);
        check("R6", "both zero low", int'(pwm_out), 0);

        // leave and re-enter pulse mode
        tag = "R9";
        wr(0, 2); wr(1, 2); wr(2, 0); run_ticks(5);
        wr(2, 1);
        check("R9", "re-entry low", int'(pwm_out), 0);
        run_ticks(1);
        check("R9", "first pulse high", int'(pwm_out), 1);

        // random mix
        tag = "R7";
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            bit tk, we;
            int sel, d;
            tk = ($urandom % 10) < 7;
            we = ($urandom % 20) == 0;
            sel = $urandom % 4;
            d = $urandom % 6;
            cyc(tk, we, sel, d);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule